// File: doc/BRIEF.md
# Fragmenting Reply Frame Transmitter

This block answers queued commands with reply frames on a byte-wide transmit stream. It takes one command record at a time from a show-ahead command FIFO. For each command it sends a fragment header, an echo of the command and, for a read command, payload bytes fetched from a local memory through a read port with one cycle of latency. Every frame closes with a 16-bit ones-complement checksum.

A read reply may be longer than the payload limit `MAX_PAY`. In that case the reply is cut into several frames. Every fragment except the last carries exactly `MAX_PAY` payload bytes. A read pointer carries the memory position from one fragment to the next. Each fragment header states its own start address and payload count, so a receiver can put the data back together without tracking state. The transmitter holds everything while the downstream `tx_ready` is low.

Top module: `reply_frame_tx`

## Requirements
- R1: After reset, and whenever the FIFO holds no command, `tx_valid` is 0. A frame starts only in the cycle after a command has been popped.
- R2: `cmd_pop` is high for exactly one cycle per command, only while `cmd_valid` is high and no frame is in progress. The next command is taken only after the last byte of the previous reply has been accepted.
- R3: A frame starts with a 6-byte header in this order: the tag byte `FRAME_TAG` (default 0xD7), the fragment index (0 for the first fragment of a reply, +1 for each further fragment, 8 bits), the fragment start address (16 bits, most significant byte first), and the fragment payload count (16 bits, most significant byte first).
- R4: The header is followed by a 5-byte echo of the command record: code, address high, address low, length high, length low. `cmd_data` is packed as {code[39:32], address[31:16], length[15:0]}.
- R5: A command whose code is not `READ_CODE` (default 0x01), or a read of length 0, gives one 13-byte frame. Its payload count is 0, its start address is the command address, and the checksum follows the echo directly.
- R6: For a read, the payload bytes are memory bytes at consecutive addresses starting at the command address, in order, with no byte skipped or repeated. The 16-bit address wraps from 0xFFFF to 0x0000.
- R7: A read of length L is sent as ceil(L/`MAX_PAY`) frames. All frames carry `MAX_PAY` payload bytes except the last, which carries the rest. Each fragment's start address follows on from the end of the one before, and no frame is longer than 13+`MAX_PAY` bytes.
- R8: The last two bytes of each frame are the checksum, most significant byte first. The checksum is the bitwise inverse of the ones-complement sum of 16-bit words formed from all earlier bytes of that frame. The byte at even position 2k is the high half of word k, and an odd trailing byte is padded with a zero low half.
- R9: `tx_last` is high only on the second checksum byte of every frame.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values. A byte counts as sent only on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command FIFO not empty |
| cmd_data | input | 40 | Command record at the FIFO head |
| cmd_pop | output | 1 | Remove the head record |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read byte address |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The bound checker watches the stream handshake on every cycle:
- one-cycle pops that happen only when the FIFO holds a command and the block is not busy;
- frames that start only after a pop;
- output held steady while back-pressured;
- frame lengths between 13 and 13+`MAX_PAY` bytes.

Byte content can only be shown by the bench's scenarios, which predict every frame from the command alone. That covers the header fields, the echo, the memory order across fragment boundaries and address wrap, the per-frame checksum values, and where the last flag falls. These scenarios run under steady, irregular and sparse ready patterns.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  localparam int BYTE_W     = 8;
  localparam int CODE_W     = 8;
  localparam int ADDR_W     = 16;
  localparam int LEN_W      = 16;
  localparam int CMD_W      = CODE_W + ADDR_W + LEN_W;
  localparam int HDR_BYTES  = 6;
  localparam int ECHO_BYTES = 5;
  localparam int IDX_W      = $clog2(HDR_BYTES);
  localparam int FIDX_W     = 8;
  localparam int CSUM_W     = 16;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_ECHO,
    ST_PAY,
    ST_CK_HI,
    ST_CK_LO
  } tx_st_t;

  function automatic logic [LEN_W-1:0] clip_len(input logic [LEN_W-1:0] left,
                                                input logic [LEN_W-1:0] limit);
    return (left > limit) ? limit : left;
  endfunction
endpackage

// File: rtl/rtx_rst_sync.sv
module rtx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rtx_csum.sv
module rtx_csum import rtx_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CSUM_W-1:0] csum_out
);
  logic [CSUM_W-1:0] sum_q, sum_d;
  logic              odd_q, odd_d;
  logic [CSUM_W-1:0] word;
  logic [CSUM_W:0]   wide;

  // Even byte positions fill the upper half of a word, odd ones the lower half.
  always_comb begin
    word  = odd_q ? {{(CSUM_W-BYTE_W){1'b0}}, byte_in} : {byte_in, {(CSUM_W-BYTE_W){1'b0}}};
    wide  = {1'b0, sum_q} + {1'b0, word};
    sum_d = sum_q;
    odd_d = odd_q;
    if (clr) begin
      sum_d = '0;
      odd_d = 1'b0;
    end else if (add_en) begin
      // end-around carry keeps the sum in ones-complement form
      sum_d = wide[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, wide[CSUM_W]};
      odd_d = ~odd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      odd_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      odd_q <= odd_d;
    end
  end

  assign csum_out = ~sum_q;
endmodule

// File: rtl/rtx_field_sel.sv
module rtx_field_sel import rtx_pkg::*; #(
  parameter logic [BYTE_W-1:0] FRAME_TAG = 8'hD7
) (
  input  tx_st_t            st,
  input  logic [IDX_W-1:0]  idx,
  input  logic [FIDX_W-1:0] frag_idx,
  input  logic [ADDR_W-1:0] frag_addr,
  input  logic [LEN_W-1:0]  frag_len,
  input  cmd_t              cmd,
  input  logic [CSUM_W-1:0] csum,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [BYTE_W-1:0] byte_out
);
  logic [BYTE_W-1:0] hdr_b  [HDR_BYTES];
  logic [BYTE_W-1:0] echo_b [ECHO_BYTES];

  always_comb begin
    hdr_b[0] = FRAME_TAG;
    hdr_b[1] = frag_idx;
    hdr_b[2] = frag_addr[15:8];
    hdr_b[3] = frag_addr[7:0];
    hdr_b[4] = frag_len[15:8];
    hdr_b[5] = frag_len[7:0];
    echo_b[0] = cmd.code;
    echo_b[1] = cmd.addr[15:8];
    echo_b[2] = cmd.addr[7:0];
    echo_b[3] = cmd.len[15:8];
    echo_b[4] = cmd.len[7:0];
  end

  always_comb begin
    byte_out = '0;
    unique case (st)
      ST_HDR:   byte_out = (int'(idx) < HDR_BYTES)  ? hdr_b[idx]  : '0;
      ST_ECHO:  byte_out = (int'(idx) < ECHO_BYTES) ? echo_b[idx] : '0;
      ST_PAY:   byte_out = mem_rdata;
      ST_CK_HI: byte_out = csum[15:8];
      ST_CK_LO: byte_out = csum[7:0];
      default:  byte_out = '0;
    endcase
  end
endmodule

// File: rtl/reply_frame_tx.sv
module reply_frame_tx import rtx_pkg::*; #(
  parameter int                MAX_PAY   = 1472,
  parameter logic [BYTE_W-1:0] FRAME_TAG = 8'hD7,
  parameter logic [CODE_W-1:0] READ_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic              cmd_pop,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  localparam logic [LEN_W-1:0] MAX_LEN   = LEN_W'(MAX_PAY);
  localparam logic [IDX_W-1:0] HDR_END   = IDX_W'(HDR_BYTES - 1);
  localparam logic [IDX_W-1:0] ECHO_END  = IDX_W'(ECHO_BYTES - 1);

  logic rst_sync_n;

  tx_st_t            st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [FIDX_W-1:0] fidx_q, fidx_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [LEN_W-1:0]  flen_q, flen_d;
  logic [LEN_W-1:0]  pleft_q, pleft_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] rptr_q, rptr_d;
  cmd_t              cmd_q, cmd_d;

  cmd_t              cmd_in;
  logic              need_data;
  logic [LEN_W-1:0]  first_rem;
  logic [LEN_W-1:0]  next_len;
  logic              accept;
  logic              sum_clr;
  logic              sum_add;
  logic [CSUM_W-1:0] csum;

  rtx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cmd_in    = cmd_t'(cmd_data);
  assign need_data = (cmd_in.code == READ_CODE) && (cmd_in.len != '0);
  assign first_rem = need_data ? cmd_in.len : '0;
  assign tx_valid  = (st_q != ST_IDLE);
  assign tx_last   = (st_q == ST_CK_LO);
  assign accept    = tx_valid && tx_ready;

  // Next-state and datapath control
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    fidx_d   = fidx_q;
    faddr_d  = faddr_q;
    flen_d   = flen_q;
    pleft_d  = pleft_q;
    rem_d    = rem_q;
    rptr_d   = rptr_q;
    cmd_d    = cmd_q;
    cmd_pop  = 1'b0;
    sum_clr  = 1'b0;
    sum_add  = 1'b0;
    next_len = clip_len(rem_q, MAX_LEN);

    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid && rst_sync_n) begin
          cmd_pop = 1'b1;
          cmd_d   = cmd_in;
          rem_d   = first_rem;
          flen_d  = clip_len(first_rem, MAX_LEN);
          pleft_d = clip_len(first_rem, MAX_LEN);
          rptr_d  = cmd_in.addr;
          faddr_d = cmd_in.addr;
          fidx_d  = '0;
          idx_d   = '0;
          sum_clr = 1'b1;
          st_d    = ST_HDR;
        end
      end
      ST_HDR: begin
        if (accept) begin
          sum_add = 1'b1;
          if (idx_q == HDR_END) begin
            idx_d = '0;
            st_d  = ST_ECHO;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_ECHO: begin
        if (accept) begin
          sum_add = 1'b1;
          if (idx_q == ECHO_END) begin
            idx_d = '0;
            st_d  = (flen_q != '0) ? ST_PAY : ST_CK_HI;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_PAY: begin
        if (accept) begin
          sum_add = 1'b1;
          rptr_d  = rptr_q + 1'b1;
          pleft_d = pleft_q - 1'b1;
          if (pleft_q == LEN_W'(1)) begin
            rem_d = rem_q - flen_q;
            st_d  = ST_CK_HI;
          end
        end
      end
      ST_CK_HI: begin
        if (accept) st_d = ST_CK_LO;
      end
      ST_CK_LO: begin
        if (accept) begin
          if (rem_q != '0) begin
            fidx_d  = fidx_q + 1'b1;
            flen_d  = next_len;
            pleft_d = next_len;
            faddr_d = rptr_q;
            idx_d   = '0;
            sum_clr = 1'b1;
            st_d    = ST_HDR;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // The read issued now returns the byte presented in the next payload cycle.
  assign mem_rd_en = (st_d == ST_PAY);
  assign mem_addr  = rptr_d;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      fidx_q  <= '0;
      faddr_q <= '0;
      flen_q  <= '0;
      pleft_q <= '0;
      rem_q   <= '0;
      rptr_q  <= '0;
      cmd_q   <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      fidx_q  <= fidx_d;
      faddr_q <= faddr_d;
      flen_q  <= flen_d;
      pleft_q <= pleft_d;
      rem_q   <= rem_d;
      rptr_q  <= rptr_d;
      cmd_q   <= cmd_d;
    end
  end

  rtx_csum u_csum (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (sum_clr),
    .add_en   (sum_add),
    .byte_in  (tx_data),
    .csum_out (csum)
  );

  rtx_field_sel #(.FRAME_TAG(FRAME_TAG)) u_sel (
    .st        (st_q),
    .idx       (idx_q),
    .frag_idx  (fidx_q),
    .frag_addr (faddr_q),
    .frag_len  (flen_q),
    .cmd       (cmd_q),
    .csum      (csum),
    .mem_rdata (mem_rdata),
    .byte_out  (tx_data)
  );
endmodule

// File: rtl/rtx_checker.sv
module rtx_checker #(
  parameter int MAX_PAY = 1472
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_pop,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last
);
  localparam int CNT_W = 17;
  logic [CNT_W-1:0] cnt_q;

  // bytes accepted so far in the current frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt_q <= '0;
    else if (tx_valid && tx_ready && tx_last) cnt_q <= '0;
    else if (tx_valid && tx_ready)            cnt_q <= cnt_q + 1'b1;
  end

  p_pop_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_valid);
  p_pop_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |=> !cmd_pop);
  p_no_pop_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !cmd_pop);
  p_start_after_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(cmd_pop));
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  p_frame_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last) |-> (cnt_q <= CNT_W'(12 + MAX_PAY)));
  p_frame_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last) |-> (cnt_q >= CNT_W'(12)));
endmodule

bind reply_frame_tx rtx_checker #(.MAX_PAY(MAX_PAY)) i_rtx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_pop   (cmd_pop),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_last   (tx_last)
);

// File: tb/test_reply_frame_tx.sv
module test_reply_frame_tx;
  localparam int         MAXP  = 6;
  localparam logic [7:0] TAG   = 8'hD7;
  localparam logic [7:0] RDC   = 8'h01;
  localparam int         LIMIT = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [39:0] cmd_data;
  logic        cmd_pop;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        tx_ready;

  always #5 clk = ~clk;

  reply_frame_tx #(.MAX_PAY(MAXP), .FRAME_TAG(TAG), .READ_CODE(RDC)) i_reply_frame_tx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_pop(cmd_pop), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready));

  typedef struct {
    logic [7:0] d;
    logic       l;
    string      tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [39:0] cmd_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pops = 0;
  int cmds_sent = 0;
  int ready_mode = 0;
  logic monitor_on = 1'b0;
  logic pop_pend = 1'b0;
  logic stall_prev = 1'b0;
  logic [7:0] stall_d;
  logic       stall_l;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return 8'((a[7:0] * 3) + a[15:8]) ^ 8'h5A;
  endfunction

  // bench memory: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rdata <= memf(mem_addr);
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: predicts every frame of the reply and queues the command
  task automatic send_cmd(input logic [7:0] code, input logic [15:0] addr, input logic [15:0] len);
    logic [15:0] rem;
    logic [15:0] ptr;
    logic [7:0]  fi;
    rem = (code == RDC && len != 0) ? len : 16'd0;
    ptr = addr;
    fi  = 8'd0;
    cmd_q.push_back({code, addr, len});
    cmds_sent++;
    do begin
      logic [7:0]  b[$];
      string       t[$];
      logic [15:0] n;
      int unsigned tot;
      logic [15:0] ck;
      n = (rem > 16'(MAXP)) ? 16'(MAXP) : rem;
      b.push_back(TAG);        t.push_back("R3");
      b.push_back(fi);         t.push_back("R7");
      b.push_back(ptr[15:8]);  t.push_back("R7");
      b.push_back(ptr[7:0]);   t.push_back("R7");
      b.push_back(n[15:8]);    t.push_back("R7");
      b.push_back(n[7:0]);     t.push_back("R7");
      b.push_back(code);       t.push_back("R4");
      b.push_back(addr[15:8]); t.push_back("R4");
      b.push_back(addr[7:0]);  t.push_back("R4");
      b.push_back(len[15:8]);  t.push_back("R4");
      b.push_back(len[7:0]);   t.push_back("R4");
      for (int i = 0; i < int'(n); i++) begin
        b.push_back(memf(ptr + 16'(i)));
        t.push_back("R6");
      end
      tot = 0;
      for (int i = 0; i < b.size(); i++)
        tot += (i % 2 == 0) ? {16'd0, b[i], 8'd0} : {24'd0, b[i]};
      while (tot > 32'hFFFF) tot = (tot & 32'hFFFF) + (tot >> 16);
      ck = ~tot[15:0];
      for (int i = 0; i < b.size(); i++) exp_q.push_back('{b[i], 1'b0, t[i]});
      exp_q.push_back('{ck[15:8], 1'b0, (n == 0) ? "R5" : "R8"});
      exp_q.push_back('{ck[7:0], 1'b1, "R8/R9"});
      rem = rem - n;
      ptr = ptr + n;
      fi  = fi + 8'd1;
    end while (rem != 0);
  endtask

  // monitor: samples at the falling edge, compares accepted bytes with the scoreboard
  always @(negedge clk) begin
    if (monitor_on) begin
      if (stall_prev)
        check(tx_valid && tx_data == stall_d && tx_last == stall_l, "R10", "held byte/last",
              {23'd0, tx_valid, tx_data}, {23'd1, stall_d});
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected byte", {24'd0, tx_data}, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(tx_data == e.d && tx_last == e.l, e.tag, "byte/last",
                {23'd0, tx_last, tx_data}, {23'd0, e.l, e.d});
        end
      end
      stall_prev = tx_valid && !tx_ready;
      stall_d    = tx_data;
      stall_l    = tx_last;
      pop_pend   = cmd_pop;
      if (cmd_pop) pops++;
    end
  end

  // command FIFO model and ready pattern, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    if (pop_pend) begin
      void'(cmd_q.pop_front());
      pop_pend = 1'b0;
    end
    cmd_valid = (cmd_q.size() > 0);
    cmd_data  = (cmd_q.size() > 0) ? cmd_q[0] : 40'd0;
    case (ready_mode)
      0:       tx_ready = 1'b1;
      1:       tx_ready = ($urandom % 3) != 0;
      default: tx_ready = (cyc % 4) == 0;
    endcase
  end

  task automatic drain;
    while ((exp_q.size() != 0 || cmd_q.size() != 0) && cyc < LIMIT) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc >= LIMIT);
    check(1'b0, "R1", "watchdog expired", cyc, LIMIT);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_data = '0;
    tx_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tx_valid && !cmd_pop, "R1", "reset state valid/pop", {31'd0, tx_valid}, 32'd0);
    monitor_on = 1'b1;
    // R1: no command, ready high -> nothing leaves the block
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!tx_valid, "R1", "idle valid", {31'd0, tx_valid}, 32'd0);
    end
    // steady ready: R5 non-read and zero-length, R6 short read
    send_cmd(8'h22, 16'h1234, 16'd10);
    send_cmd(RDC, 16'h0040, 16'd0);
    send_cmd(RDC, 16'h0100, 16'd4);
    drain();
    // irregular ready: R7 multi-fragment with tail, exact multiple
    ready_mode = 1;
    send_cmd(RDC, 16'h00F0, 16'd13);
    send_cmd(RDC, 16'h0200, 16'd12);
    drain();
    // sparse ready: R6 address wrap across fragments, R2 back-to-back queue
    ready_mode = 2;
    send_cmd(RDC, 16'hFFFE, 16'd7);
    send_cmd(8'h7F, 16'hABCD, 16'd0);
    send_cmd(RDC, 16'h0333, 16'd1);
    drain();
    ready_mode = 0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7", "bytes still expected", exp_q.size(), 0);
    check(pops == cmds_sent, "R2", "pop count", pops, cmds_sent);
    check(!tx_valid, "R1", "idle after drain", {31'd0, tx_valid}, 32'd0);
    finish_run();
  end
endmodule